// File: doc/BRIEF.md
# Serial Memory Front End with Pause and Status Write Guard

This block is the serial front end of a memory device that acts as a slave on an SPI bus in mode 0. It shifts in an opcode and data bytes, and it drives serial data out. It owns an 8-bit status register made up of a lock-down bit and block-protection bits. Two opcodes are handled here: one writes the status register and one reads it out. All other opcodes are left to other logic. Every bus pin is sampled on the system clock and edges are found from the samples, so the serial clock must run well below the system clock.

A pause input stops a transfer part way through without losing its position. Entry into pause and exit from it both take effect only while the serial clock is low. During a pause the output enable is deasserted, and serial clock and data activity is ignored. Raising chip select during a pause clears all transfer state. A write-protect input decides whether the lock-down bit has any effect on status writes.

Top module: `spi_flash_front`

## Requirements
- R1: Input bits are sampled on rising serial-clock edges, MSB first. The first byte after chip select falls is the opcode. Bit and byte position clear whenever chip select is high.
- R2: Opcode 0x05 drives the status register out MSB first. Each bit changes on a falling serial-clock edge, starting with the falling edge after the opcode's eighth bit. The register repeats every 8 bits for as long as chip select stays low.
- R3: `spi_sdo_en` is 1 only during the data phase of opcode 0x05, while chip select is low and the block is not paused. At all other times it is 0, which marks the output as high-impedance.
- R4: Opcode 0x01 followed by one data byte updates the status register only when chip select rises after exactly 16 bits. A frame of 15 or 17 bits leaves the register unchanged.
- R5: A status write is refused when `spi_wp_n` is 0 and status bit 7 (the lock-down bit) is 1.
- R6: A status write is accepted when `spi_wp_n` is 1, or when status bit 7 is 0.
- R7: Only status bits 7, 5, 4, 3 and 2 can be written. Bits 6, 1 and 0 keep their reset value of 0.
- R8: The block enters pause at once if `spi_hold_n` is low while the serial clock is low. If the serial clock is high when `spi_hold_n` falls, entry waits until the clock next goes low.
- R9: Exit from pause follows the same rule. If `spi_hold_n` rises while the clock is low, exit is immediate. If it rises while the clock is high, exit waits for the next low phase.
- R10: While paused, serial data and clock edges are ignored and the bit and byte position keep their values. The pause lasts for as long as `spi_hold_n` stays low.
- R11: Pause applies only while chip select is low. Raising chip select during a pause ends the pause and clears the transfer, so the next frame starts again from bit 0.
- R12: After reset the status register is 0x00 and `spi_sdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_sdi | input | 1 | Serial data from the master |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_wp_n | input | 1 | Write-protect, active low |
| spi_sdo | output | 1 | Serial data to the master |
| spi_sdo_en | output | 1 | Output driver enable; 0 means high-impedance |

## Verification
The hardest cases are the deferred pause entry and exit, where `spi_hold_n` changes in the middle of a serial-clock high phase. In that case the following falling edge must be processed exactly once: it is taken on entry and dropped on exit. The bench reaches these cases by splitting a real bit of a status read. It raises the clock for that bit, moves the pause input while the clock is high, and checks the output enable before and after the clock falls. Then it toggles clock and data while paused, and confirms that the status byte still reads back whole. Dropping chip select during a pause is shown to reset the transfer, by running a fresh, properly aligned write straight afterwards.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;
    localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic sdi;
        logic hold_n;
        logic wp_n;
    } pin_s;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic cs_rise;
    } edge_s;

    // Which byte of the frame is being shifted in
    typedef enum logic [1:0] {
        PH_OPCODE = 2'd0,
        PH_BYTE1  = 2'd1,
        PH_BYTE2  = 2'd2,
        PH_OVER   = 2'd3
    } phase_e;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_OPCODE: return PH_BYTE1;
            PH_BYTE1:  return PH_BYTE2;
            default:   return PH_OVER;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] merge_masked(
        input logic [BYTE_W-1:0] old_v,
        input logic [BYTE_W-1:0] new_v,
        input logic [BYTE_W-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler
    import spi_fe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pin_s  pins_raw,
    output pin_s  pins,
    output edge_s edges
);
    logic sck_d;
    logic cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins  <= '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0, hold_n: 1'b1, wp_n: 1'b1};
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            pins  <= pins_raw;
            sck_d <= pins.sck;
            cs_d  <= pins.cs_n;
        end
    end

    always_comb begin
        edges.sck_rise = pins.sck & ~sck_d;
        edges.sck_fall = ~pins.sck & sck_d;
        edges.cs_rise  = pins.cs_n & ~cs_d;
    end

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
    import spi_fe_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pin_s pins,
    output logic paused
);
    // Changes take effect only in the serial clock low phase
    always_ff @(posedge clk) begin
        if (rst || pins.cs_n) begin
            paused <= 1'b0;
        end else if (!pins.sck) begin
            paused <= ~pins.hold_n;
        end
    end

    p_cs_ends_hold_r11: assert property (@(posedge clk) disable iff (rst)
        pins.cs_n |=> !paused);
    p_enter_low_r8: assert property (@(posedge clk) disable iff (rst)
        (!pins.cs_n && !pins.hold_n && !pins.sck) |=> paused);
    p_stay_held_r10: assert property (@(posedge clk) disable iff (rst)
        (paused && !pins.hold_n && !pins.cs_n) |=> paused);
    p_no_change_high_r9: assert property (@(posedge clk) disable iff (rst)
        (!pins.cs_n && pins.sck) |=> $stable(paused));

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  pin_s                 pins,
    input  edge_s                edges,
    input  logic                 paused,
    input  logic [BYTE_W-1:0]    status,
    output phase_e               phase,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output logic [BYTE_W-1:0]    opcode,
    output logic [BYTE_W-1:0]    data_byte,
    output logic                 sdo_bit,
    output logic                 rd_active
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shift_in;
    logic [BYTE_W-1:0] shift_out;
    logic [BYTE_W-1:0] next_byte;

    assign next_byte = {shift_in[BYTE_W-2:0], pins.sdi};
    assign rd_active = (opcode == OP_RDSR) && (phase != PH_OPCODE);

    always_ff @(posedge clk) begin
        if (rst || pins.cs_n) begin
            phase     <= PH_OPCODE;
            bit_idx   <= '0;
            opcode    <= '0;
            data_byte <= '0;
            shift_in  <= '0;
            shift_out <= '0;
            sdo_bit   <= 1'b0;
        end else if (!paused) begin
            if (edges.sck_rise) begin
                shift_in <= next_byte;
                bit_idx  <= bit_idx + 1'b1;
                if (bit_idx == LAST_BIT) begin
                    phase <= next_phase(phase);
                    if (phase == PH_OPCODE) opcode <= next_byte;
                    if (phase == PH_BYTE1)  data_byte <= next_byte;
                end
            end
            if (edges.sck_fall && rd_active) begin
                if (bit_idx == '0) begin
                    sdo_bit   <= status[BYTE_W-1];
                    shift_out <= {status[BYTE_W-2:0], 1'b0};
                end else begin
                    sdo_bit   <= shift_out[BYTE_W-1];
                    shift_out <= {shift_out[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    p_counts_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (paused && !pins.cs_n) |=> ($stable(bit_idx) && $stable(phase) && $stable(sdo_bit)));
    p_deselect_clears_r1: assert property (@(posedge clk) disable iff (rst)
        pins.cs_n |=> (bit_idx == '0 && phase == PH_OPCODE));

endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg
    import spi_fe_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RST_VAL  = 8'h00,
    parameter logic [BYTE_W-1:0] WR_MASK  = 8'hBC,
    parameter int                LOCK_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              wp_n,
    input  logic [BYTE_W-1:0] wr_val,
    output logic [BYTE_W-1:0] status
);
    logic allowed;
    assign allowed = wp_n | ~status[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= RST_VAL;
        end else if (wr_req && allowed) begin
            status <= merge_masked(status, wr_val, WR_MASK);
        end
    end

    p_locked_refuse_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !wp_n && status[LOCK_BIT]) |=> $stable(status));
    p_fixed_bits_r7: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> $stable(status & ~WR_MASK));
    p_no_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> $stable(status));

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
    import spi_fe_pkg::*;
#(
    parameter logic [7:0] STATUS_RST = 8'h00,
    parameter logic [7:0] STATUS_WR_MASK = 8'hBC,
    parameter int         LOCK_BIT = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_sdi,
    input  logic spi_hold_n,
    input  logic spi_wp_n,
    output logic spi_sdo,
    output logic spi_sdo_en
);
    pin_s                 pins_raw;
    pin_s                 pins;
    edge_s                edges;
    logic                 paused;
    phase_e               phase;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [BYTE_W-1:0]    opcode;
    logic [BYTE_W-1:0]    data_byte;
    logic [BYTE_W-1:0]    status;
    logic                 sdo_bit;
    logic                 rd_active;
    logic                 wr_req;

    assign pins_raw = '{cs_n: spi_cs_n, sck: spi_sck, sdi: spi_sdi,
                        hold_n: spi_hold_n, wp_n: spi_wp_n};

    spi_pin_sampler u_sampler (
        .clk(clk), .rst(rst), .pins_raw(pins_raw), .pins(pins), .edges(edges)
    );

    spi_hold_ctrl u_hold (
        .clk(clk), .rst(rst), .pins(pins), .paused(paused)
    );

    spi_frame_engine u_engine (
        .clk(clk), .rst(rst), .pins(pins), .edges(edges), .paused(paused),
        .status(status), .phase(phase), .bit_idx(bit_idx), .opcode(opcode),
        .data_byte(data_byte), .sdo_bit(sdo_bit), .rd_active(rd_active)
    );

    // Commit only when the frame closes on exactly two whole bytes
    assign wr_req = edges.cs_rise && (opcode == OP_WRSR) &&
                    (phase == PH_BYTE2) && (bit_idx == '0);

    spi_status_reg #(
        .RST_VAL(STATUS_RST), .WR_MASK(STATUS_WR_MASK), .LOCK_BIT(LOCK_BIT)
    ) u_status (
        .clk(clk), .rst(rst), .wr_req(wr_req), .wp_n(pins.wp_n),
        .wr_val(data_byte), .status(status)
    );

    assign spi_sdo    = sdo_bit;
    assign spi_sdo_en = !pins.cs_n && !paused && rd_active;

    p_hz_in_hold_r3: assert property (@(posedge clk) disable iff (rst)
        paused |-> !spi_sdo_en);
    p_hz_deselect_r3: assert property (@(posedge clk) disable iff (rst)
        pins.cs_n |-> !spi_sdo_en);

endmodule

// File: tb/spi_flash_front_tb.sv
module spi_flash_front_tb;

    localparam int H = 4;
    localparam logic [7:0] MASK = 8'hBC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic sdo, sdo_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_stat = 8'h00;

    always #4 clk = ~clk;

    spi_flash_front u_dut (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_sdi(sdi),
        .spi_hold_n(hold_n), .spi_wp_n(wp_n), .spi_sdo(sdo), .spi_sdo_en(sdo_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic garbage_while_held(input string req);
        for (int k = 0; k < 3; k++) begin
            sdi = ~sdi;
            sck = 1'b1; tick(H);
            chk(sdo_en === 1'b0, req, sdo_en, 0);
            sck = 1'b0; tick(H);
        end
    endtask

    // hold_mode: 0 none, 1 immediate at start of bit, 2 deferred in bit's high phase
    task automatic xfer(input logic [31:0] tx, input int nbits, input int hold_bit,
                        input int hold_mode, input bit rd, output logic [31:0] rx);
        bit en_exp;
        rx = '0;
        cs_n = 1'b0; tick(H);
        for (int i = 0; i < nbits; i++) begin
            en_exp = rd && (i >= 8);
            if (i == hold_bit && hold_mode == 1) begin
                hold_n = 1'b0; tick(3);
                chk(sdo_en === 1'b0, "R8 immediate entry", sdo_en, 0);
                garbage_while_held("R10 held");
                hold_n = 1'b1; tick(3);
                chk(sdo_en === en_exp, "R9 immediate exit", sdo_en, en_exp);
            end
            sdi = tx[31-i]; tick(H);
            rx[31-i] = sdo;
            if (rd && i >= 8) chk(sdo_en === 1'b1, "R3 enable in data phase", sdo_en, 1);
            sck = 1'b1; tick(H);
            if (i == hold_bit && hold_mode == 2) begin
                hold_n = 1'b0; tick(3);
                chk(sdo_en === en_exp, "R8 entry deferred while high", sdo_en, en_exp);
                sck = 1'b0; tick(3);
                chk(sdo_en === 1'b0, "R8 entry at clock low", sdo_en, 0);
                tick(H);
                garbage_while_held("R10 held");
                sck = 1'b1; tick(H);
                hold_n = 1'b1; tick(3);
                chk(sdo_en === 1'b0, "R9 exit deferred while high", sdo_en, 0);
                sck = 1'b0; tick(3);
                chk(sdo_en === en_exp, "R9 exit at clock low", sdo_en, en_exp);
            end else begin
                sck = 1'b0;
            end
        end
        tick(H);
        cs_n = 1'b1; tick(H);
        chk(sdo_en === 1'b0, "R3 idle after deselect", sdo_en, 0);
    endtask

    task automatic wr_status(input logic [7:0] v, input int nbits, input int hb, input int hm);
        logic [31:0] rx;
        xfer({8'h01, v, 16'h0000}, nbits, hb, hm, 1'b0, rx);
    endtask

    task automatic rd_status(output logic [7:0] v, input int hb, input int hm);
        logic [31:0] rx;
        xfer({8'h05, 24'h0}, 16, hb, hm, 1'b1, rx);
        v = rx[23:16];
    endtask

    task automatic model_write(input logic [7:0] v);
        if (wp_n || !exp_stat[7]) exp_stat = (exp_stat & ~MASK) | (v & MASK);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk(sdo_en === 1'b0, "R12 enable after reset", sdo_en, 0);
        rd_status(v, -1, 0);
        chk(v === 8'h00, "R12 status after reset", v, 0);
    endtask

    task automatic t_basic;
        logic [7:0] v;
        wp_n = 1'b1;
        wr_status(8'hFF, 16, -1, 0); model_write(8'hFF);
        rd_status(v, -1, 0);
        chk(v === exp_stat, "R7 only writable bits set", v, exp_stat);
        wr_status(8'h2C, 16, -1, 0); model_write(8'h2C);
        rd_status(v, -1, 0);
        chk(v === exp_stat, "R1 R2 write then read", v, exp_stat);
    endtask

    task automatic t_repeat;
        logic [31:0] rx;
        xfer({8'h05, 24'h0}, 32, -1, 0, 1'b1, rx);
        chk(rx[23:16] === exp_stat, "R2 first byte", rx[23:16], exp_stat);
        chk(rx[15:8] === exp_stat, "R2 repeat byte 2", rx[15:8], exp_stat);
        chk(rx[7:0] === exp_stat, "R2 repeat byte 3", rx[7:0], exp_stat);
    endtask

    task automatic t_protect;
        logic [7:0] v;
        wp_n = 1'b1;
        wr_status(8'h84, 16, -1, 0); model_write(8'h84);
        wp_n = 1'b0;
        wr_status(8'h00, 16, -1, 0);
        rd_status(v, -1, 0);
        chk(v === 8'h84, "R5 locked write refused", v, 8'h84);
        wp_n = 1'b1;
        wr_status(8'h08, 16, -1, 0); model_write(8'h08);
        rd_status(v, -1, 0);
        chk(v === 8'h08, "R6 write with wp high", v, 8'h08);
        wp_n = 1'b0;
        wr_status(8'h30, 16, -1, 0); model_write(8'h30);
        rd_status(v, -1, 0);
        chk(v === 8'h30, "R6 write with lock clear", v, 8'h30);
        wp_n = 1'b1;
    endtask

    task automatic t_bitcount;
        logic [7:0] v;
        wr_status(8'h1C, 15, -1, 0);
        rd_status(v, -1, 0);
        chk(v === exp_stat, "R4 fifteen bits ignored", v, exp_stat);
        wr_status(8'h1C, 17, -1, 0);
        rd_status(v, -1, 0);
        chk(v === exp_stat, "R4 seventeen bits ignored", v, exp_stat);
        wr_status(8'h1C, 16, -1, 0); model_write(8'h1C);
        rd_status(v, -1, 0);
        chk(v === 8'h1C, "R4 sixteen bits commit", v, 8'h1C);
    endtask

    task automatic t_hold_read;
        logic [7:0] v;
        rd_status(v, 11, 1);
        chk(v === exp_stat, "R10 read across immediate hold", v, exp_stat);
        rd_status(v, 13, 2);
        chk(v === exp_stat, "R10 read across deferred hold", v, exp_stat);
    endtask

    task automatic t_hold_write;
        logic [7:0] v;
        wr_status(8'hA8, 16, 3, 1); model_write(8'hA8);
        rd_status(v, -1, 0);
        chk(v === exp_stat, "R10 write across immediate hold", v, exp_stat);
        wr_status(8'h24, 16, 12, 2); model_write(8'h24);
        rd_status(v, -1, 0);
        chk(v === exp_stat, "R10 write across deferred hold", v, exp_stat);
    endtask

    task automatic t_cs_in_hold;
        logic [7:0] v;
        logic [15:0] fr;
        fr = {8'h01, 8'h98};
        cs_n = 1'b0; tick(H);
        for (int i = 0; i < 10; i++) begin
            sdi = fr[15-i]; tick(H);
            sck = 1'b1; tick(H);
            sck = 1'b0;
        end
        tick(H);
        hold_n = 1'b0; tick(H);
        cs_n = 1'b1; tick(H);
        chk(sdo_en === 1'b0, "R11 deselect in hold", sdo_en, 0);
        hold_n = 1'b1; tick(H);
        rd_status(v, -1, 0);
        chk(v === exp_stat, "R11 aborted frame no commit", v, exp_stat);
        wr_status(8'h14, 16, -1, 0); model_write(8'h14);
        rd_status(v, -1, 0);
        chk(v === 8'h14, "R11 fresh frame after reset", v, 8'h14);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        t_reset();
        t_basic();
        t_repeat();
        t_protect();
        t_bitcount();
        t_hold_read();
        t_hold_write();
        t_cs_in_hold();
        finished = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule